// File: doc/BRIEF.md
# Tone Generator and Modulation Selector

This block makes the nominal 22 kHz signalling tone out of the system clock and decides what drives the tone output. Three sources are possible. The first is a free-running tone. The second is the internal tone switched on and off by an envelope on an external pin. The third is an already modulated signal from that same pin, passed straight through. One counter chain produces both the tone and the converter switching strobe. The strobe runs at twenty times the tone rate, so the two stay phase-locked. The block also supplies the select line that chooses the tone-decoder threshold.

Software sets two control bits. The tone-enable bit `ent` has priority: when it is set, the tone runs whatever the other inputs are doing. When `ent` is clear, the modulation-select bit `msel` picks between envelope gating and passthrough. The external pin is synchronized before use. In envelope mode the gate stays open for one full tone period after the last synchronized rising edge of the pin. Changes of gate and mode are applied only on tone half-period boundaries, so the generated tone never carries a shortened pulse.

Top module: `tone_mod_sel`

## Requirements
- R1: While `rst_n` is low and right after it rises, `tone_out` is 0. `sw_en` is a one-cycle strobe that is high in one clock cycle out of every SW_DIV. It is first high after SW_DIV-1 rising edges following reset release.
- R2: The internal tone has a 50 % duty cycle and a half period of SW_DIV*TONE_RATIO/2 clocks. It is low after reset and first goes high at rising edge number SW_DIV*TONE_RATIO/2 after release. Each tone period holds exactly TONE_RATIO `sw_en` strobes.
- R3: With `ent`=1, `tone_out` follows the internal tone regardless of `msel` and `extm`.
- R4: With `ent`=0 and `msel`=1, `tone_out` equals `extm` delayed by two clock edges (two-flop synchronizer).
- R5: With `ent`=0 and `msel`=0, `tone_out` is the internal tone while the envelope is open and 0 while it is closed. The envelope is open while synchronized `extm` is 1.
- R6: Each synchronized rising edge of `extm` holds the envelope open for SW_DIV*TONE_RATIO clocks (one tone period), even if `extm` falls sooner.
- R7: Changes of mode and of envelope gating take effect only at tone half-period boundaries. Outside passthrough, `tone_out` never changes level inside a half period.
- R8: `thr_sel` is `txt` OR `tth`. 0 selects the receive threshold and 1 selects the transmit threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ent | input | 1 | Tone-enable control bit, highest priority |
| msel | input | 1 | Modulation select: 1 passthrough, 0 envelope gating |
| extm | input | 1 | External envelope or modulated tone pin, asynchronous |
| txt | input | 1 | Transmit indication pin for the decoder threshold |
| tth | input | 1 | Threshold control bit |
| tone_out | output | 1 | Selected tone output |
| sw_en | output | 1 | Converter switching strobe, twenty per tone period |
| thr_sel | output | 1 | Decoder threshold select, 1 = transmit |

## Verification
The bench starts a short `extm` pulse just after a boundary and samples a full half period later. A gate without the one-period hold would show silence there, and a hold that ended too late would keep the tone alive one half period too long. An envelope that opens in the middle of a high half must produce no output until the next high half. Immediate gating would show a runt pulse at once. Exact samples on both sides of a boundary, a strobe count over one period, and a two-edge passthrough latency check expose an off-by-one divider, a wrong ratio, or a missing or extra synchronizer stage. ENT-over-MSEL priority is checked with `extm` held active.

// File: rtl/tone_pkg.sv
package tone_pkg;

  typedef enum logic [1:0] {
    TM_GATED = 2'd0,
    TM_CONT  = 2'd1,
    TM_PASS  = 2'd2
  } tone_mode_e;

  // Control-bit priority: tone enable wins over modulation select.
  function automatic tone_mode_e pick_mode(input logic ent, input logic msel);
    if (ent)       return TM_CONT;
    else if (msel) return TM_PASS;
    else           return TM_GATED;
  endfunction

  // Envelope hold length in clocks: one full tone period.
  function automatic int hold_clks(input int sw_div, input int ratio);
    return sw_div * ratio;
  endfunction

  // Output selection for a latched mode.
  function automatic logic drive_out(input tone_mode_e mode, input logic tone,
                                     input logic gate, input logic ext);
    case (mode)
      TM_CONT: return tone;
      TM_PASS: return ext;
      default: return tone & gate;
    endcase
  endfunction

endpackage

// File: rtl/tone_divider.sv
module tone_divider #(
  parameter int SW_DIV     = 4,
  parameter int TONE_RATIO = 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic sw_en,
  output logic half_bnd,
  output logic tone_int
);
  localparam int HALF = TONE_RATIO / 2;
  localparam int SW_W = (SW_DIV > 1) ? $clog2(SW_DIV) : 1;
  localparam int PH_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [SW_W-1:0] SW_LAST = SW_W'(SW_DIV - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF - 1);

  logic [SW_W-1:0] sw_cnt;
  logic [PH_W-1:0] ph_cnt;

  assign sw_en    = (sw_cnt == SW_LAST);
  assign half_bnd = sw_en && (ph_cnt == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_cnt   <= '0;
      ph_cnt   <= '0;
      tone_int <= 1'b0;
    end else begin
      sw_cnt <= sw_en ? '0 : sw_cnt + SW_W'(1);
      if (sw_en) ph_cnt <= half_bnd ? '0 : ph_cnt + PH_W'(1);
      if (half_bnd) tone_int <= ~tone_int;
    end
  end
endmodule

// File: rtl/extm_sync.sv
module extm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic extm,
  output logic ext_sync,
  output logic ext_rise
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], extm};
  end

  assign ext_sync = pipe[STAGES-1];
  assign ext_rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/tone_gate.sv
module tone_gate
  import tone_pkg::*;
#(
  parameter int HOLD_CLKS = 80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ent,
  input  logic       msel,
  input  logic       half_bnd,
  input  logic       tone_int,
  input  logic       ext_sync,
  input  logic       ext_rise,
  output logic       tone_out,
  output logic       hold_active,
  output tone_mode_e mode_q
);
  localparam int HOLD_W = $clog2(HOLD_CLKS + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CLKS);

  logic [HOLD_W-1:0] hold_cnt;
  logic              gate_q;
  logic              env;

  assign hold_active = (hold_cnt != '0);
  assign env         = ext_sync | hold_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      gate_q   <= 1'b0;
      mode_q   <= TM_GATED;
    end else begin
      if (ext_rise)         hold_cnt <= HOLD_LOAD;
      else if (hold_active) hold_cnt <= hold_cnt - HOLD_W'(1);
      if (half_bnd) begin
        mode_q <= pick_mode(ent, msel);
        gate_q <= env;
      end
    end
  end

  assign tone_out = drive_out(mode_q, tone_int, gate_q, ext_sync);
endmodule

// File: rtl/tone_mod_sel.sv
module tone_mod_sel
  import tone_pkg::*;
#(
  parameter int SW_DIV     = 4,
  parameter int TONE_RATIO = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ent,
  input  logic msel,
  input  logic extm,
  input  logic txt,
  input  logic tth,
  output logic tone_out,
  output logic sw_en,
  output logic thr_sel
);
  localparam int HOLD = hold_clks(SW_DIV, TONE_RATIO);

  logic       half_bnd;
  logic       tone_int;
  logic       ext_sync;
  logic       ext_rise;
  logic       hold_active;
  tone_mode_e mode_q;

  tone_divider #(.SW_DIV(SW_DIV), .TONE_RATIO(TONE_RATIO)) u_div (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .half_bnd(half_bnd), .tone_int(tone_int)
  );

  extm_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .extm(extm), .ext_sync(ext_sync), .ext_rise(ext_rise)
  );

  tone_gate #(.HOLD_CLKS(HOLD)) u_gate (
    .clk(clk), .rst_n(rst_n), .ent(ent), .msel(msel), .half_bnd(half_bnd),
    .tone_int(tone_int), .ext_sync(ext_sync), .ext_rise(ext_rise),
    .tone_out(tone_out), .hold_active(hold_active), .mode_q(mode_q)
  );

  assign thr_sel = txt | tth;
endmodule

// File: rtl/tone_mod_sel_chk.sv
module tone_mod_sel_chk
  import tone_pkg::*;
#(
  parameter int SW_DIV     = 4,
  parameter int TONE_RATIO = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ent,
  input logic       txt,
  input logic       tone_out,
  input logic       sw_en,
  input logic       thr_sel,
  input logic       half_bnd,
  input logic       tone_int,
  input logic       ext_sync,
  input logic       hold_active,
  input tone_mode_e mode_q
);
  localparam int HALF = TONE_RATIO / 2;
  int unsigned strobes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  strobes <= 0;
    else if (half_bnd)           strobes <= 0;
    else if (sw_en)              strobes <= strobes + 1;
  end

  p_sw_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |=> !sw_en);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> !tone_out);

  p_ratio_r2: assert property (@(posedge clk) disable iff (!rst_n)
    half_bnd |-> (strobes == HALF - 1));

  p_tone_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    half_bnd |=> (tone_int != $past(tone_int)));

  p_cont_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (half_bnd && ent) |=> (tone_out == tone_int));

  p_hold_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_sync) |=> hold_active);

  p_no_runt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_bnd && mode_q != TM_PASS) |=> $stable(tone_out));

  p_thr_tx_r8: assert property (@(posedge clk) txt |-> thr_sel);
endmodule

bind tone_mod_sel tone_mod_sel_chk #(.SW_DIV(SW_DIV), .TONE_RATIO(TONE_RATIO)) u_chk (
  .clk(clk), .rst_n(rst_n), .ent(ent), .txt(txt), .tone_out(tone_out), .sw_en(sw_en),
  .thr_sel(thr_sel), .half_bnd(half_bnd), .tone_int(tone_int), .ext_sync(ext_sync),
  .hold_active(hold_active), .mode_q(mode_q)
);

// File: tb/tone_mod_sel_tb.sv
module tone_mod_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SW_DIV     = 4;
  localparam int TONE_RATIO = 20;
  localparam int HALF_CLKS  = SW_DIV * TONE_RATIO / 2;
  localparam int TONE_CLKS  = 2 * HALF_CLKS;

  // {ent, msel, extm, expected kind}; kind 0 = silent, 1 = tone, 2 = follows extm
  localparam logic [4:0] VEC [0:9] = '{
    5'b000_00, 5'b100_01, 5'b101_01, 5'b110_01, 5'b011_10,
    5'b010_10, 5'b001_01, 5'b011_10, 5'b000_00, 5'b111_01
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ent = 1'b0, msel = 1'b0, extm = 1'b0, txt = 1'b0, tth = 1'b0;
  logic tone_out, sw_en, thr_sel;
  int   k = 0;
  int   n_chk = 0;
  int   n_bad = 0;

  tone_mod_sel #(.SW_DIV(SW_DIV), .TONE_RATIO(TONE_RATIO)) u_dut (
    .clk(clk), .rst_n(rst_n), .ent(ent), .msel(msel), .extm(extm),
    .txt(txt), .tth(tth), .tone_out(tone_out), .sw_en(sw_en), .thr_sel(thr_sel)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) if (rst_n) k <= k + 1;

  function automatic logic exp_tone(input int edges);
    return ((edges / HALF_CLKS) % 2) == 1;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at k=%0d actual=%0b expected=%0b", req, k, act, exp);
    end
  endtask

  task automatic to_phase(input int p, input int m);
    do @(negedge clk); while ((k % m) != p);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 tone in reset", tone_out, 1'b0);
    chk("R1 strobe in reset", sw_en, 1'b0);
    rst_n = 1'b1;
    chk("R1 tone after release", tone_out, 1'b0);
    for (int i = 0; i < 4; i++) begin
      chk("R1 first strobe", sw_en, (i == SW_DIV - 1));
      @(negedge clk);
    end

    // R8 threshold select, bits {txt,tth}
    for (int i = 0; i < 4; i++) begin
      txt = i[1]; tth = i[0];
      #1 chk("R8 threshold", thr_sel, i[1] | i[0]);
    end
    txt = 1'b0; tth = 1'b0;

    // R2 strobe count and phase over one tone period
    begin
      int cnt = 0;
      logic phase_ok = 1'b1;
      to_phase(0, TONE_CLKS);
      for (int i = 0; i < TONE_CLKS; i++) begin
        if (sw_en) cnt++;
        if (sw_en !== ((k % SW_DIV) == SW_DIV - 1)) phase_ok = 1'b0;
        @(negedge clk);
      end
      chk("R2 strobes per period", cnt == TONE_RATIO, 1'b1);
      chk("R1 strobe phase", phase_ok, 1'b1);
    end

    // Vector table: R3 R4 R5
    for (int v = 0; v < 10; v++) begin
      to_phase(2, HALF_CLKS);
      ent = VEC[v][4]; msel = VEC[v][3]; extm = VEC[v][2];
      to_phase(5, HALF_CLKS);
      to_phase(5, HALF_CLKS);
      for (int s = 0; s < 8; s++) begin
        logic e;
        case (VEC[v][1:0])
          2'd1:    e = exp_tone(k);
          2'd2:    e = VEC[v][2];
          default: e = 1'b0;
        endcase
        chk(VEC[v][4] ? "R3 vector" : (VEC[v][3] ? "R4 vector" : "R5 vector"), tone_out, e);
        repeat (10) @(negedge clk);
      end
    end

    // R2 exact boundary in continuous mode (ent still 1)
    to_phase(HALF_CLKS - 1, TONE_CLKS); chk("R2 before rise", tone_out, 1'b0);
    @(negedge clk);                     chk("R2 at rise", tone_out, 1'b1);
    to_phase(TONE_CLKS - 1, TONE_CLKS); chk("R2 before fall", tone_out, 1'b1);
    @(negedge clk);                     chk("R2 at fall", tone_out, 1'b0);

    // R4 passthrough latency
    ent = 1'b0; msel = 1'b1; extm = 1'b0;
    repeat (2 * TONE_CLKS) @(negedge clk);
    extm = 1'b1;
    @(negedge clk); chk("R4 one edge", tone_out, 1'b0);
    @(negedge clk); chk("R4 two edges", tone_out, 1'b1);
    extm = 1'b0;
    @(negedge clk); chk("R4 fall one edge", tone_out, 1'b1);
    @(negedge clk); chk("R4 fall two edges", tone_out, 1'b0);

    // R6 short pulse held for one tone period
    msel = 1'b0;
    repeat (3 * TONE_CLKS) @(negedge clk);
    to_phase(2, TONE_CLKS);
    extm = 1'b1;
    repeat (3) @(negedge clk);
    extm = 1'b0;
    to_phase(HALF_CLKS + 1, TONE_CLKS);
    begin
      logic steady = 1'b1;
      for (int i = HALF_CLKS + 1; i < TONE_CLKS; i++) begin
        if (tone_out !== 1'b1) steady = 1'b0;
        @(negedge clk);
      end
      chk("R6 held high half", steady, 1'b1);
    end
    to_phase(HALF_CLKS + 10, TONE_CLKS);
    chk("R6 closed after hold", tone_out, 1'b0);

    // R7 envelope opening mid high-half waits for a boundary
    to_phase(HALF_CLKS + 5, TONE_CLKS);
    extm = 1'b1;
    to_phase(HALF_CLKS + 10, TONE_CLKS); chk("R7 no runt early", tone_out, 1'b0);
    to_phase(HALF_CLKS + 30, TONE_CLKS); chk("R7 no runt late", tone_out, 1'b0);
    to_phase(5, TONE_CLKS);              chk("R7 low half", tone_out, 1'b0);
    to_phase(HALF_CLKS + 5, TONE_CLKS);  chk("R5 gate open", tone_out, 1'b1);
    extm = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule